// File: doc/BRIEF.md
# Mode-Dependent Accumulator Rounding Unit

This block rounds a wide accumulator word at a bit position that follows the current scaling mode. The high portion of the accumulator is usually read out after a one-bit shift, up or down. Moving the rounding point with the scaling mode keeps the result correctly rounded for whichever portion is read out. Every bit at or below the rounding position is cleared in the result.

A rounding-type input picks the method. Two's complement rounding sends an exact half upward. Convergent rounding sends an exact half to the neighbour whose lowest kept bit is zero. The result is registered: an operand presented with a valid strobe comes out one clock later with its own valid flag. The output word wraps modulo the accumulator width, and nothing is saturated.

With the default parameters the accumulator is 40 bits and the nominal rounding position is bit 15. The scaling modes then give positions 15, 16 and 14.

Top module: `acc_round_unit`

## Requirements
- R1: With `in_scale` = 2'b00 (no scaling) the rounding position is NOM_POS, so the result has bits [NOM_POS:0] cleared and is rounded on bit NOM_POS.
- R2: With `in_scale` = 2'b01 (scale down) the rounding position is NOM_POS+1.
- R3: With `in_scale` = 2'b10 (scale up) the rounding position is NOM_POS-1.
- R4: With `in_scale` = 2'b11 (reserved) the rounding position is NOM_POS, the same as 2'b00.
- R5: With `in_rnd_twos` = 1 (two's complement), the result is rounded up when the discarded field (bits at or below position p) is at least 2^p, and truncated otherwise. Rounding up adds 2^(p+1) to the truncated value.
- R6: With `in_rnd_twos` = 0 (convergent), a discarded field above 2^p rounds up and one below 2^p truncates. When the field equals exactly 2^p, the result is the one of the two candidates whose bit p+1 is zero.
- R7: Rounding up from the largest truncated value wraps the result modulo 2^ACC_W, with no saturation.
- R8: `out_valid` is `in_valid` delayed by exactly one clock, and `out_data` then holds the rounded value of the operand, scaling mode and rounding type sampled at that edge.
- R9: While `in_valid` is low, `out_data` keeps its previous value, whatever the other inputs do.
- R10: While `rst_n` is low, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | ACC_W | Accumulator operand |
| in_scale | input | 2 | Scaling mode: 00 none, 01 down, 10 up, 11 reserved |
| in_rnd_twos | input | 1 | Rounding type: 0 convergent, 1 two's complement |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | ACC_W | Rounded result, low bits cleared |

## Verification
The bench builds the unit with ACC_W = 12 and NOM_POS = 4, which puts the rounding positions at bits 3, 4 and 5. At that width every 12-bit operand can be applied under all four scaling modes and both rounding types, one vector per clock. The sweep therefore covers every exact-half tie with both parities of the bit above the rounding position. It also covers every wrap from the top of the range. Hold behaviour with the strobe low and the state during reset are checked separately.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;

   typedef enum logic [1:0] {
      SCL_NONE = 2'b00,
      SCL_DOWN = 2'b01,
      SCL_UP   = 2'b10,
      SCL_RSVD = 2'b11
   } scale_e;

   // Selection of the rounding variant built into the core
   localparam int RND_RUNTIME    = 0;
   localparam int RND_FIXED_TWOS = 1;
   localparam int RND_FIXED_CONV = 2;

endpackage

// File: rtl/acc_round_pos_decode.sv
module acc_round_pos_decode
   import acc_round_pkg::*;
#(
   parameter int ACC_W   = 40,
   parameter int NOM_POS = 15
) (
   input  scale_e             scale,
   output logic [ACC_W-1:0]   half_vec,   // one-hot at the rounding position
   output logic [ACC_W-1:0]   drop_mask,  // ones at and below the rounding position
   output logic [ACC_W-1:0]   lsb_vec     // one-hot just above the rounding position
);
   localparam int POS_W    = $clog2(ACC_W + 1);
   localparam int POS_DOWN = NOM_POS + 1;
   localparam int POS_UP   = NOM_POS - 1;

   logic [POS_W-1:0] pos;

   always_comb begin
      unique case (scale)
         SCL_DOWN: pos = POS_W'(POS_DOWN);
         SCL_UP:   pos = POS_W'(POS_UP);
         default:  pos = POS_W'(NOM_POS);
      endcase
   end

   for (genvar i = 0; i < ACC_W; i++) begin : g_bit
      assign half_vec[i]  = (pos == POS_W'(i));
      assign drop_mask[i] = (POS_W'(i) <= pos);
      if (i == 0) begin : g_lsb0
         assign lsb_vec[i] = 1'b0;
      end else begin : g_lsbn
         assign lsb_vec[i] = (pos == POS_W'(i - 1));
      end
   end

endmodule

// File: rtl/acc_round_core.sv
module acc_round_core
   import acc_round_pkg::*;
#(
   parameter int ACC_W     = 40,
   parameter int RND_BUILD = RND_RUNTIME
) (
   input  logic [ACC_W-1:0] data,
   input  logic [ACC_W-1:0] half_vec,
   input  logic [ACC_W-1:0] drop_mask,
   input  logic [ACC_W-1:0] lsb_vec,
   input  logic             twos_sel,
   output logic             tie,
   output logic [ACC_W-1:0] result
);
   logic [ACC_W-1:0] bumped;
   logic [ACC_W-1:0] up_trunc;
   logic             conv_eff;

   assign bumped   = data + half_vec;
   assign up_trunc = bumped & ~drop_mask;
   assign tie      = ((data & drop_mask) == half_vec);

   if (RND_BUILD == RND_FIXED_TWOS) begin : g_twos
      assign conv_eff = 1'b0;
   end else if (RND_BUILD == RND_FIXED_CONV) begin : g_conv
      assign conv_eff = 1'b1;
   end else begin : g_runtime
      assign conv_eff = ~twos_sel;
   end

   // On an exact half, clearing the bit above the rounding position
   // yields the even candidate in either direction.
   assign result = (tie && conv_eff) ? (up_trunc & ~lsb_vec) : up_trunc;

endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit
   import acc_round_pkg::*;
#(
   parameter int ACC_W     = 40,
   parameter int NOM_POS   = 15,
   parameter int RND_BUILD = RND_RUNTIME
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [ACC_W-1:0] in_data,
   input  logic [1:0]       in_scale,
   input  logic             in_rnd_twos,
   output logic             out_valid,
   output logic [ACC_W-1:0] out_data
);
   if (NOM_POS < 2 || NOM_POS + 3 > ACC_W) begin : g_bad_pos
      $error("acc_round_unit: NOM_POS must lie in [2, ACC_W-3]");
   end
   if (RND_BUILD < RND_RUNTIME || RND_BUILD > RND_FIXED_CONV) begin : g_bad_rnd
      $error("acc_round_unit: RND_BUILD out of range");
   end

   logic [ACC_W-1:0] half_vec, drop_mask, lsb_vec, rounded;
   logic             tie;
   scale_e           scale;

   assign scale = scale_e'(in_scale);

   acc_round_pos_decode #(.ACC_W(ACC_W), .NOM_POS(NOM_POS)) u_dec (
      .scale     (scale),
      .half_vec  (half_vec),
      .drop_mask (drop_mask),
      .lsb_vec   (lsb_vec)
   );

   acc_round_core #(.ACC_W(ACC_W), .RND_BUILD(RND_BUILD)) u_core (
      .data      (in_data),
      .half_vec  (half_vec),
      .drop_mask (drop_mask),
      .lsb_vec   (lsb_vec),
      .twos_sel  (in_rnd_twos),
      .tie       (tie),
      .result    (rounded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= rounded;
      end
   end

   // R8: one-cycle strobe latency
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9: result held while idle
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
   // R3: even the lowest rounding position clears the bits under NOM_POS
   a_r3_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[NOM_POS-1:0] == '0));
   // R1: exactly one rounding position is selected
   a_r1_single_pos: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> $onehot(half_vec));
   // R6: a convergent tie leaves the bit above the position clear
   a_r6_tie_even: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && tie && !in_rnd_twos && RND_BUILD != RND_FIXED_TWOS)
      |=> ((out_data & $past(lsb_vec)) == '0));

endmodule

// File: tb/acc_round_unit_bench.sv
module acc_round_unit_bench;
   localparam int W = 12;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [1:0]   in_scale = 2'b00;
   logic         in_rnd_twos = 1'b0;
   logic         out_valid;
   logic [W-1:0] out_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   acc_round_unit #(.ACC_W(W), .NOM_POS(N)) u_acc_round_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_scale(in_scale), .in_rnd_twos(in_rnd_twos),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic int pos_of(input int sm);
      if (sm == 1) return N + 1;
      if (sm == 2) return N - 1;
      return N;
   endfunction

   // Arithmetic reference model; also reports tie and wrap
   function automatic logic [W-1:0] ref_round(input int x, input int sm, input int rm,
                                              output bit is_tie, output bit is_wrap);
      int p, step, rem, trunc, up, half;
      bit go_up;
      p     = pos_of(sm);
      step  = 1 << (p + 1);
      half  = 1 << p;
      rem   = x % step;
      trunc = x - rem;
      is_tie = (rem == half);
      if (rem > half)      go_up = 1'b1;
      else if (rem < half) go_up = 1'b0;
      else if (rm != 0)    go_up = 1'b1;
      else                 go_up = ((trunc / step) % 2) == 1;
      up = trunc + step;
      is_wrap = go_up && (up >= (1 << W));
      return go_up ? W'(up % (1 << W)) : W'(trunc);
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] exp_v;
      logic [W-1:0] held;
      bit t, w;
      string tag;

      repeat (3) @(negedge clk);
      check("R10 out_valid in reset", W'(out_valid), '0);
      check("R10 out_data in reset", out_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 out_valid after reset", W'(out_valid), '0);

      for (int sm = 0; sm < 4; sm++) begin
         for (int rm = 0; rm < 2; rm++) begin
            for (int x = 0; x < (1 << W); x++) begin
               in_valid    = 1'b1;
               in_data     = W'(x);
               in_scale    = 2'(sm);
               in_rnd_twos = rm[0];
               exp_v = ref_round(x, sm, rm, t, w);
               @(negedge clk);
               case (sm)
                  0: tag = "R1";
                  1: tag = "R2";
                  2: tag = "R3";
                  default: tag = "R4";
               endcase
               tag = {tag, (rm != 0) ? " R5" : " R6"};
               if (w) tag = {tag, " R7"};
               if (t) tag = {tag, " tie"};
               check({tag, " value"}, out_data, exp_v);
               check("R8 out_valid after strobe", W'(out_valid), W'(1));
            end
         end
      end

      // R9: idle cycles with changing inputs must not disturb the result
      held = out_data;
      for (int k = 0; k < 8; k++) begin
         in_valid    = 1'b0;
         in_data     = W'(k * 397 + 5);
         in_scale    = 2'(k);
         in_rnd_twos = k[0];
         @(negedge clk);
         check("R9 out_data held", out_data, held);
         check("R8 out_valid low when idle", W'(out_valid), '0);
      end

      // R10: reset in the middle of operation
      in_valid = 1'b1;
      in_data  = W'(12'hABC);
      rst_n    = 1'b0;
      @(negedge clk);
      check("R10 out_data on reset", out_data, '0);
      check("R10 out_valid on reset", W'(out_valid), '0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule